// File: doc/BRIEF.md
# High-Resolution Color Math Pixel Combiner

This block forms the final colors of a double-width output line. For every low-resolution pixel position it receives one main screen color and one sub screen color, each 15 bits packed as three 5-bit channels (red in bits 4..0, green in bits 9..5, blue in bits 14..10). It produces two half-pixels per position, a left one and a right one, as a stream at twice the pixel rate. Each half is built with per-channel add or subtract color math, optionally halved.

The right half blends the current main color with the math operand. The left half blends the math operand with the main color of the position just to its left. The operand is the sub screen color, or a stored fixed color when selected. Whether math applies at all is decided once per position, from a 6-bit per-layer mask indexed by the main pixel's layer tag, and that single decision governs both halves. The fixed color lives in three 5-bit registers, loaded through a byte whose top three bits pick the channels.

Pixels are presented with `pix_valid` at most once every two clock cycles; the block emits one half-pixel per cycle.

Top module: `hires_color_combiner`

## Requirements
- R1: After reset `out_valid` and `out_right` are low and `out_rgb` is zero.
- R2: A pixel accepted at a clock edge appears as its left half (`out_right`=0) in the following cycle and as its right half (`out_right`=1) in the cycle after that, each with `out_valid` high.
- R3: When math is enabled, the right half is `main_rgb` combined with the operand, channel by channel.
- R4: When math is enabled, the left half is the operand combined with the main color of the previously accepted pixel; when `line_first` is high that previous color is taken as black (all zero).
- R5: Without halving, addition saturates each channel at 31 and subtraction (`op_subtract`=1, result = first minus second) clamps each channel at 0.
- R6: With `op_half`=1 each channel is shifted right by one after the operation: addition gives (a+b)>>1 with no saturation, subtraction gives max(a-b,0)>>1.
- R7: Math is enabled when `main_layer` is below 6 and `math_mask[main_layer]` is 1; tags 6 and 7 are never enabled. When disabled, the left half is `sub_rgb` and the right half is `main_rgb` unchanged.
- R8: The mask, layer, operand and operation are sampled only at the edge that accepts the pixel; changing them in the cycle before the right half is shown does not alter that right half.
- R9: A `fix_we` write updates the fixed-color channels whose select bit is set (bit 7 blue, bit 6 green, bit 5 red) with `fix_byte[4:0]`; unselected channels keep their value, a write with no select bit changes nothing, and reset clears all three to zero. A write takes effect for pixels accepted from the next edge on.
- R10: With `use_fixed`=1 the fixed color replaces the sub screen color as the operand of both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | A pixel position is presented this cycle |
| line_first | input | 1 | The presented pixel is the first of a line |
| main_rgb | input | 15 | Main screen color |
| sub_rgb | input | 15 | Sub screen color |
| main_layer | input | 3 | Layer tag of the main pixel (0..5 valid layers) |
| math_mask | input | 6 | Per-layer math enable mask |
| use_fixed | input | 1 | Use the fixed color as operand instead of the sub color |
| op_subtract | input | 1 | 1 subtract, 0 add |
| op_half | input | 1 | Halve the result |
| fix_we | input | 1 | Fixed-color write strobe |
| fix_byte | input | 8 | Fixed-color write: bits 7..5 channel select, bits 4..0 value |
| out_valid | output | 1 | A half-pixel is on `out_rgb` |
| out_right | output | 1 | 0 for the left half, 1 for the right half |
| out_rgb | output | 15 | Output half-pixel color |

## Verification
The bench builds the block with its default sizing: 5-bit channels, three channels and six mask layers, so the 3-bit layer tag can reach the two codes above the mask width and exercise their forced disable. With 5-bit channels, saturation at 31, clamping at 0 and the unsaturated halving of a 62 sum are all reachable with directed values, and a random stream across line starts checks the left half's reliance on the previous main pixel against an independent model.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
    localparam int CH_W     = 5;
    localparam int N_CH     = 3;
    localparam int COLOR_W  = CH_W * N_CH;
    localparam int N_LAYERS = 6;
    localparam int LAYER_W  = $clog2(N_LAYERS);
    localparam int SEL_LSB  = CH_W;

    typedef logic [COLOR_W-1:0] color_t;

    typedef struct packed {
        logic   out_valid;
        logic   out_right;
        color_t out_rgb;
        color_t hold_rgb;
        color_t prev_main;
    } pipe_state_t;
endpackage

// File: rtl/hcm_chan_math.sv
module hcm_chan_math #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         op_sub,
    input  logic         op_half,
    output logic [W-1:0] y
);
    logic [W:0]   sum;
    logic [W:0]   diff;
    logic [W-1:0] clipped;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, a} - {1'b0, b};
        if (op_sub)
            clipped = diff[W] ? '0 : diff[W-1:0];
        else
            clipped = sum[W] ? '1 : sum[W-1:0];
        if (op_half)
            y = op_sub ? {1'b0, clipped[W-1:1]} : sum[W:1];
        else
            y = clipped;
    end

    // R5: a saturating add never falls below its first input
    always_comb begin
        if (!op_sub && !op_half)
            a_r5_add_not_below: assert (y >= a);
    end

    // R5/R6: subtraction never exceeds its first input
    always_comb begin
        if (op_sub)
            a_r5_sub_not_above: assert (y <= a);
    end
endmodule

// File: rtl/hcm_fixed_reg.sv
module hcm_fixed_reg
    import hcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wbyte,
    output color_t     fixed_rgb
);
    logic [N_CH-1:0][CH_W-1:0] fix_d, fix_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        always_comb begin
            fix_d[c] = fix_q[c];
            if (we && wbyte[SEL_LSB + c])
                fix_d[c] = wbyte[CH_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fix_q[c] <= '0;
            else        fix_q[c] <= fix_d[c];
        end
    end

    assign fixed_rgb = fix_q;

    // R9: a write selecting no channel leaves the register untouched
    a_r9_no_select_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wbyte[7:5] == 3'b000) |=> $stable(fixed_rgb));

    // R9: selecting red loads the written value into the red field
    a_r9_red_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wbyte[5]) |=> (fixed_rgb[4:0] == $past(wbyte[4:0])));
endmodule

// File: rtl/hires_color_combiner.sv
module hires_color_combiner
    import hcm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_valid,
    input  logic         line_first,
    input  logic [14:0]  main_rgb,
    input  logic [14:0]  sub_rgb,
    input  logic [2:0]   main_layer,
    input  logic [5:0]   math_mask,
    input  logic         use_fixed,
    input  logic         op_subtract,
    input  logic         op_half,
    input  logic         fix_we,
    input  logic [7:0]   fix_byte,
    output logic         out_valid,
    output logic         out_right,
    output logic [14:0]  out_rgb
);
    localparam int EXT_W = 1 << LAYER_W;

    pipe_state_t st_d, st_q;
    color_t      fixed_rgb;
    color_t      operand;
    color_t      prev_main;
    color_t      left_math, right_math;
    color_t      left_rgb, right_rgb;
    logic [EXT_W-1:0] mask_ext;
    logic        math_on;

    hcm_fixed_reg i_fixed (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (fix_we),
        .wbyte     (fix_byte),
        .fixed_rgb (fixed_rgb)
    );

    always_comb begin
        operand   = use_fixed ? fixed_rgb : sub_rgb;
        prev_main = line_first ? '0 : st_q.prev_main;
        mask_ext  = EXT_W'(math_mask);
        math_on   = (32'(main_layer) < N_LAYERS) && mask_ext[main_layer];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        hcm_chan_math #(.W(CH_W)) i_right (
            .a       (main_rgb[c*CH_W +: CH_W]),
            .b       (operand[c*CH_W +: CH_W]),
            .op_sub  (op_subtract),
            .op_half (op_half),
            .y       (right_math[c*CH_W +: CH_W])
        );
        hcm_chan_math #(.W(CH_W)) i_left (
            .a       (operand[c*CH_W +: CH_W]),
            .b       (prev_main[c*CH_W +: CH_W]),
            .op_sub  (op_subtract),
            .op_half (op_half),
            .y       (left_math[c*CH_W +: CH_W])
        );
    end

    always_comb begin
        left_rgb  = math_on ? left_math  : sub_rgb;
        right_rgb = math_on ? right_math : main_rgb;

        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_right = 1'b0;
        if (pix_valid) begin
            st_d.out_valid = 1'b1;
            st_d.out_rgb   = left_rgb;
            st_d.hold_rgb  = right_rgb;
            st_d.prev_main = main_rgb;
        end else if (st_q.out_valid && !st_q.out_right) begin
            st_d.out_valid = 1'b1;
            st_d.out_right = 1'b1;
            st_d.out_rgb   = st_q.hold_rgb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_right = st_q.out_right;
    assign out_rgb   = st_q.out_rgb;

    // R2: an accepted pixel shows its left half next cycle
    a_r2_left_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (out_valid && !out_right));

    // R2: a left half is always followed by its right half
    a_r2_right_follows_left: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_right) |=> (out_valid && out_right));

    // R4: at a line start a plain add leaves the operand as the left half
    a_r4_line_start_black: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_first && math_on && !use_fixed && !op_subtract && !op_half)
        |=> (out_rgb == $past(sub_rgb)));

    // R7: with math off the right half is the raw main color
    a_r7_disabled_right: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !math_on) |=> ##1 (out_rgb == $past(main_rgb, 2)));
endmodule

// File: tb/test_hires_color_combiner.sv
`timescale 1ns/1ps
module test_hires_color_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic        line_first = 1'b0;
    logic [14:0] main_rgb = '0;
    logic [14:0] sub_rgb = '0;
    logic [2:0]  main_layer = '0;
    logic [5:0]  math_mask = '0;
    logic        use_fixed = 1'b0;
    logic        op_subtract = 1'b0;
    logic        op_half = 1'b0;
    logic        fix_we = 1'b0;
    logic [7:0]  fix_byte = '0;
    logic        out_valid;
    logic        out_right;
    logic [14:0] out_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [14:0] exp_q[$];
    logic        side_q[$];
    string       tag_q[$];

    logic [14:0] m_prev  = '0;
    logic [4:0]  m_fix[3] = '{5'd0, 5'd0, 5'd0};

    always #2.5 clk = ~clk;

    hires_color_combiner i_hires_color_combiner (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_first(line_first),
        .main_rgb(main_rgb), .sub_rgb(sub_rgb), .main_layer(main_layer),
        .math_mask(math_mask), .use_fixed(use_fixed), .op_subtract(op_subtract),
        .op_half(op_half), .fix_we(fix_we), .fix_byte(fix_byte),
        .out_valid(out_valid), .out_right(out_right), .out_rgb(out_rgb)
    );

    function automatic logic [14:0] rgb(input int r, input int g, input int b);
        return {5'(b), 5'(g), 5'(r)};
    endfunction

    function automatic logic [4:0] ch_op(input logic [4:0] a, input logic [4:0] b,
                                         input bit s, input bit h);
        int r;
        if (s) begin
            r = int'(a) - int'(b);
            if (r < 0) r = 0;
            if (h) r = r / 2;
        end else begin
            r = int'(a) + int'(b);
            if (h) r = r / 2;
            else if (r > 31) r = 31;
        end
        return 5'(r);
    endfunction

    function automatic logic [14:0] col_op(input logic [14:0] a, input logic [14:0] b,
                                           input bit s, input bit h);
        logic [14:0] y;
        for (int c = 0; c < 3; c++)
            y[c*5 +: 5] = ch_op(a[c*5 +: 5], b[c*5 +: 5], s, h);
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [14:0] act,
                         input logic [14:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fix_write(input logic [7:0] b);
        @(negedge clk);
        fix_we = 1'b1; fix_byte = b;
        for (int c = 0; c < 3; c++)
            if (b[5 + c]) m_fix[c] = b[4:0];
        @(negedge clk);
        fix_we = 1'b0;
    endtask

    // drive one pixel, push its expected halves; flip_ctl changes controls before the right half
    task automatic send(input logic [14:0] mn, input logic [14:0] sb, input int lay,
                        input logic [5:0] msk, input bit fx, input bit s, input bit h,
                        input bit first, input string tag, input bit flip_ctl = 0);
        logic [14:0] opnd, prv, fixc, l_exp, r_exp;
        bit en;
        fixc = {m_fix[2], m_fix[1], m_fix[0]};
        opnd = fx ? fixc : sb;
        prv  = first ? 15'd0 : m_prev;
        en   = (lay < 6) && msk[lay];
        l_exp = en ? col_op(opnd, prv, s, h) : sb;
        r_exp = en ? col_op(mn, opnd, s, h) : mn;
        m_prev = mn;
        exp_q.push_back(l_exp); side_q.push_back(1'b0); tag_q.push_back(tag);
        exp_q.push_back(r_exp); side_q.push_back(1'b1); tag_q.push_back(tag);
        @(negedge clk);
        pix_valid = 1'b1; line_first = first; main_rgb = mn; sub_rgb = sb;
        main_layer = 3'(lay); math_mask = msk; use_fixed = fx;
        op_subtract = s; op_half = h;
        @(negedge clk);
        pix_valid = 1'b0;
        if (flip_ctl) begin
            math_mask = ~msk; op_subtract = ~s; op_half = ~h; use_fixed = ~fx;
            main_layer = 3'(lay ^ 1); main_rgb = ~mn; sub_rgb = ~sb;
        end
    endtask

    // monitor: compare every emitted half against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", out_rgb, 15'd0);
            end else begin
                logic [14:0] e;
                logic sd;
                string t;
                e = exp_q.pop_front(); sd = side_q.pop_front(); t = tag_q.pop_front();
                check(out_right == sd, {"R2 half order ", t}, 15'(out_right), 15'(sd));
                check(out_rgb == e, t, out_rgb, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            check(1'b0, "watchdog expired", 15'd0, 15'd0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", 15'(out_valid), 15'd0);
        check(out_right == 1'b0, "R1 out_right", 15'(out_right), 15'd0);
        check(out_rgb == 15'd0, "R1 out_rgb", out_rgb, 15'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: plain add, first of line then a neighbour
        send(rgb(3, 4, 5), rgb(1, 2, 3), 0, 6'h3F, 0, 0, 0, 1, "R4 line start add");
        send(rgb(6, 7, 8), rgb(2, 2, 2), 2, 6'h3F, 0, 0, 0, 0, "R3 add with prev");
        // R5: saturation and clamping
        send(rgb(31, 20, 16), rgb(31, 12, 16), 1, 6'h3F, 0, 0, 0, 0, "R5 saturate");
        send(rgb(5, 20, 0), rgb(9, 3, 31), 3, 6'h3F, 0, 1, 0, 0, "R5 clamp");
        // R6: halving
        send(rgb(31, 10, 1), rgb(31, 5, 0), 4, 6'h3F, 0, 0, 1, 0, "R6 half add");
        send(rgb(30, 3, 17), rgb(9, 8, 2), 5, 6'h3F, 0, 1, 1, 0, "R6 half sub");
        // R7: disabled by mask and by tag above the mask
        send(rgb(12, 13, 14), rgb(1, 1, 1), 2, 6'h3B, 0, 0, 0, 0, "R7 mask bit off");
        send(rgb(9, 9, 9), rgb(4, 5, 6), 6, 6'h3F, 0, 0, 0, 0, "R7 tag 6");
        send(rgb(2, 9, 4), rgb(7, 5, 6), 7, 6'h3F, 0, 1, 0, 0, "R7 tag 7");
        // R8: controls flipped before the right half
        send(rgb(10, 11, 12), rgb(3, 3, 3), 1, 6'h02, 0, 0, 0, 0, "R8 sampled once", 1);
        send(rgb(20, 1, 5), rgb(4, 9, 2), 1, 6'h00, 0, 1, 0, 0, "R8 sampled once off", 1);
        // R9 R10: fixed color is zero after reset
        send(rgb(7, 8, 9), rgb(30, 30, 30), 0, 6'h01, 1, 0, 0, 0, "R9 reset fixed zero");
        fix_write(8'hE7);
        fix_write(8'h54);
        fix_write(8'h1F);
        send(rgb(4, 4, 4), rgb(31, 31, 31), 0, 6'h01, 1, 0, 0, 0, "R10 fixed operand");
        fix_write(8'hA3);
        send(rgb(20, 20, 20), rgb(0, 0, 0), 1, 6'h02, 1, 1, 0, 1, "R9 select blue red");
        send(rgb(1, 2, 3), rgb(5, 5, 5), 1, 6'h02, 1, 0, 1, 0, "R10 fixed half");

        // random stream
        for (int i = 0; i < 60; i++) begin
            send(15'($urandom), 15'($urandom), int'($urandom_range(0, 7)),
                 6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 (i % 9) == 0, "R3 R4 random");
            if (i % 17 == 5) fix_write(8'($urandom));
        end

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R2 missing outputs", 15'(exp_q.size()), 15'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule